// File: doc/BRIEF.md
# Converter Overrange Status and Modulator Auto-Reset Controller

This block sits next to a sigma-delta converter. Each sample clock cycle it reads a raw overrange pulse, a loop-filter saturation flag and a memory-busy flag. From these it drives a single status pin. Two configuration bits choose what the pin means. In overrange mode the pin is high when the input is out of range. In valid mode the pin is high while the converter output can be trusted.

When automatic reset is enabled, the block watches for a sustained overload. That is either an unbroken run of raw overrange cycles or a saturated loop filter. It then raises a one-cycle reset request to the modulator and holds a reset-in-progress flag for a fixed number of cycles. While that flag is high the status pin is held in its alarm state.

The same block also sends the data samples through a fixed-latency register pipeline. It produces a data clock whose capture edge can be selected.

Top module: `ovr_guard`

## Requirements
- R1: While `rst` is sampled high, and right after it, `stat_pin`, `mod_rst_req`, `rst_busy` and `dout` are all 0.
- R2: With `cfg_dvmode`=0 and `cfg_autorst`=0, `stat_pin` after a rising edge equals `ovr_raw` sampled at that edge.
- R3: With `cfg_dvmode`=1 and `cfg_autorst`=0, `stat_pin` after a rising edge equals the inverse of `mem_busy` sampled at that edge.
- R4: With `cfg_dvmode`=0 and `cfg_autorst`=1, `stat_pin` is 1 when `ovr_raw` was sampled high or `rst_busy` is high, and 0 otherwise.
- R5: With `cfg_dvmode`=1 and `cfg_autorst`=1, `stat_pin` is 0 when `mem_busy` was sampled high or `rst_busy` is high, and 1 otherwise.
- R6: With auto-reset enabled and no reset in progress, the 16th consecutive rising edge at which `ovr_raw` is sampled high makes `mod_rst_req` and `rst_busy` go to 1 after that edge. Fifteen consecutive high samples do not.
- R7: A single edge with `ovr_raw` sampled low restarts the consecutive count from zero.
- R8: With auto-reset enabled and no reset in progress, `lf_sat` sampled high starts a reset after that same edge.
- R9: With `cfg_autorst`=0, no run of overrange and no saturation starts a reset. The run count is held at zero, so a run counts only from the first edge at which auto-reset is sampled enabled.
- R10: A reset keeps `rst_busy` high for exactly RST_LEN cycles (default 8), with `mod_rst_req` high only in the first of them. The run count stays at zero throughout, and saturation or overrange during the window does not start another reset.
- R11: `dout` after rising edge n+LAT-1 equals `din` sampled at edge n (LAT=7 registers).
- R12: With `cfg_dclk_inv`=0, `dclk_out` is the inverse of `clk`, so it rises mid-way through each output data interval. With `cfg_dclk_inv`=1, `dclk_out` follows `clk`, which moves the capture point to its falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, all state on rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ovr_raw | input | 1 | Raw per-cycle overrange pulse |
| lf_sat | input | 1 | Loop-filter saturation flag |
| mem_busy | input | 1 | Calibration or factory memory transfer active |
| cfg_autorst | input | 1 | 1 enables automatic modulator reset |
| cfg_dvmode | input | 1 | 0 overrange indication, 1 data-valid indication |
| cfg_dclk_inv | input | 1 | 0 data valid on rising dclk_out, 1 on falling |
| din | input | DW | Converter sample in |
| stat_pin | output | 1 | Status pin (meaning set by mode bits) |
| mod_rst_req | output | 1 | One-cycle modulator reset request |
| rst_busy | output | 1 | Automatic reset in progress |
| dout | output | DW | Delayed sample out |
| dclk_out | output | 1 | Data clock output |

## Verification
The bench drives overrange runs of every length from 1 to past two full reset periods. A design that miscounted by one would fire on the 15th or 17th edge, and one that failed to clear the count while the reset runs would fire again too early on a held overload. A run broken by one low cycle and then resumed catches a counter that only pauses instead of restarting. Saturation arriving inside an active reset window exposes a design that restarts or stretches the window. Enabling auto-reset in the middle of a long overload catches a counter that kept counting while the feature was off.

// File: rtl/ovr_guard_pkg.sv
package ovr_guard_pkg;

  typedef enum logic {
    PIN_OVERRANGE = 1'b0,
    PIN_VALID     = 1'b1
  } pin_mode_e;

  // Level of the status pin for a given mode and input set.
  function automatic logic pin_level(input pin_mode_e mode, input logic autorst,
                                     input logic ovr, input logic mem,
                                     input logic busy);
    logic hold;
    hold = autorst & busy;
    if (mode == PIN_VALID) return ~(mem | hold);
    else                   return ovr | hold;
  endfunction

  // True on the edge that completes the required overrange run.
  function automatic logic run_done(input logic ovr, input int unsigned cnt,
                                    input int unsigned run_len);
    return ovr && (cnt == run_len - 1);
  endfunction

endpackage

// File: rtl/ovr_run_detect.sv
module ovr_run_detect
  import ovr_guard_pkg::*;
#(
  parameter int unsigned RUN_LEN = 16,
  localparam int unsigned CW = $clog2(RUN_LEN + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ovr_raw,
  input  logic          lf_sat,
  input  logic          autorst,
  input  logic          busy_q,
  output logic          trig,
  output logic [CW-1:0] run_cnt
);

  logic run_hit;
  logic armed;

  assign armed   = autorst & ~busy_q;
  assign run_hit = run_done(ovr_raw, int'(run_cnt), RUN_LEN);
  assign trig    = armed & (run_hit | lf_sat);

  always_ff @(posedge clk) begin
    if (rst) begin
      run_cnt <= '0;
    end else if (!armed || trig || !ovr_raw) begin
      run_cnt <= '0;
    end else begin
      run_cnt <= run_cnt + CW'(1);
    end
  end

endmodule

// File: rtl/ovr_rst_seq.sv
module ovr_rst_seq #(
  parameter int unsigned RST_LEN = 8,
  localparam int unsigned SW = $clog2(RST_LEN + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic trig,
  output logic busy_q,
  output logic busy_d,
  output logic req
);

  logic [SW-1:0] seq_cnt;
  logic          last;

  assign last   = (seq_cnt == SW'(RST_LEN - 1));
  assign busy_d = trig | (busy_q & ~last);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= 1'b0;
      req     <= 1'b0;
      seq_cnt <= '0;
    end else begin
      busy_q <= busy_d;
      req    <= trig;
      if (trig || !busy_q) seq_cnt <= '0;
      else                 seq_cnt <= seq_cnt + SW'(1);
    end
  end

endmodule

// File: rtl/ovr_pin_mux.sv
module ovr_pin_mux
  import ovr_guard_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic dvmode,
  input  logic autorst,
  input  logic ovr_raw,
  input  logic mem_busy,
  input  logic busy_d,
  output logic stat_pin
);

  pin_mode_e mode;
  logic      level;

  assign mode  = dvmode ? PIN_VALID : PIN_OVERRANGE;
  assign level = pin_level(mode, autorst, ovr_raw, mem_busy, busy_d);

  always_ff @(posedge clk) begin
    if (rst) stat_pin <= 1'b0;
    else     stat_pin <= level;
  end

endmodule

// File: rtl/ovr_lat_pipe.sv
module ovr_lat_pipe #(
  parameter int unsigned DW  = 12,
  parameter int unsigned LAT = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout
);

  logic [DW-1:0] stage [LAT];

  always_ff @(posedge clk) begin
    if (rst) stage[0] <= '0;
    else     stage[0] <= din;
  end

  for (genvar g = 1; g < LAT; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stage[g] <= '0;
      else     stage[g] <= stage[g-1];
    end
  end

  assign dout = stage[LAT-1];

endmodule

// File: rtl/ovr_dclk_sel.sv
module ovr_dclk_sel (
  input  logic clk,
  input  logic inv,
  output logic dclk_out
);

  assign dclk_out = inv ? clk : ~clk;

endmodule

// File: rtl/ovr_guard.sv
module ovr_guard
  import ovr_guard_pkg::*;
#(
  parameter int unsigned DW      = 12,
  parameter int unsigned LAT     = 7,
  parameter int unsigned RUN_LEN = 16,
  parameter int unsigned RST_LEN = 8,
  localparam int unsigned CW = $clog2(RUN_LEN + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ovr_raw,
  input  logic          lf_sat,
  input  logic          mem_busy,
  input  logic          cfg_autorst,
  input  logic          cfg_dvmode,
  input  logic          cfg_dclk_inv,
  input  logic [DW-1:0] din,
  output logic          stat_pin,
  output logic          mod_rst_req,
  output logic          rst_busy,
  output logic [DW-1:0] dout,
  output logic          dclk_out
);

  logic          trig;
  logic          busy_q;
  logic          busy_d;
  logic [CW-1:0] run_cnt;

  ovr_run_detect #(.RUN_LEN(RUN_LEN)) u_det (
    .clk(clk), .rst(rst), .ovr_raw(ovr_raw), .lf_sat(lf_sat),
    .autorst(cfg_autorst), .busy_q(busy_q), .trig(trig), .run_cnt(run_cnt)
  );

  ovr_rst_seq #(.RST_LEN(RST_LEN)) u_seq (
    .clk(clk), .rst(rst), .trig(trig),
    .busy_q(busy_q), .busy_d(busy_d), .req(mod_rst_req)
  );

  ovr_pin_mux u_pin (
    .clk(clk), .rst(rst), .dvmode(cfg_dvmode), .autorst(cfg_autorst),
    .ovr_raw(ovr_raw), .mem_busy(mem_busy), .busy_d(busy_d),
    .stat_pin(stat_pin)
  );

  ovr_lat_pipe #(.DW(DW), .LAT(LAT)) u_pipe (
    .clk(clk), .rst(rst), .din(din), .dout(dout)
  );

  ovr_dclk_sel u_dclk (
    .clk(clk), .inv(cfg_dclk_inv), .dclk_out(dclk_out)
  );

  assign rst_busy = busy_q;

endmodule

// File: rtl/ovr_guard_chk.sv
module ovr_guard_chk #(
  parameter int unsigned RUN_LEN = 16,
  parameter int unsigned RST_LEN = 8,
  localparam int unsigned CW = $clog2(RUN_LEN + 1),
  localparam int unsigned BW = $clog2(RST_LEN + 2)
) (
  input logic          clk,
  input logic          rst,
  input logic          ovr_raw,
  input logic          lf_sat,
  input logic          cfg_autorst,
  input logic          cfg_dvmode,
  input logic          stat_pin,
  input logic          mod_rst_req,
  input logic          rst_busy,
  input logic [CW-1:0] run_cnt
);

  logic [CW-1:0] seen_run;
  logic [BW-1:0] busy_len;

  always_ff @(posedge clk) begin
    if (rst || !ovr_raw || rst_busy) seen_run <= '0;
    else if (seen_run != CW'(RUN_LEN)) seen_run <= seen_run + CW'(1);
    if (rst || !rst_busy) busy_len <= '0;
    else                  busy_len <= busy_len + BW'(1);
  end

  AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (rst)
    mod_rst_req |=> !mod_rst_req); // R10
  AST_REQ_FRESH: assert property (@(posedge clk) disable iff (rst)
    mod_rst_req |-> rst_busy && !$past(rst_busy)); // R10
  AST_BUSY_WINDOW: assert property (@(posedge clk) disable iff (rst)
    $fell(rst_busy) |-> busy_len == BW'(RST_LEN)); // R10
  AST_RUN_HELD: assert property (@(posedge clk) disable iff (rst)
    rst_busy |-> run_cnt == '0); // R10
  AST_OFF_NO_REQ: assert property (@(posedge clk) disable iff (rst)
    mod_rst_req |-> $past(cfg_autorst)); // R9
  AST_REQ_CAUSE: assert property (@(posedge clk) disable iff (rst)
    mod_rst_req |-> $past(lf_sat) || seen_run == CW'(RUN_LEN)); // R6
  AST_NORM_HOLD: assert property (@(posedge clk) disable iff (rst)
    rst_busy && $past(cfg_autorst) && !$past(cfg_dvmode) |-> stat_pin); // R4
  AST_DV_HOLD: assert property (@(posedge clk) disable iff (rst)
    rst_busy && $past(cfg_autorst) && $past(cfg_dvmode) |-> !stat_pin); // R5

endmodule

bind ovr_guard ovr_guard_chk #(.RUN_LEN(RUN_LEN), .RST_LEN(RST_LEN)) u_chk (
  .clk(clk), .rst(rst), .ovr_raw(ovr_raw), .lf_sat(lf_sat),
  .cfg_autorst(cfg_autorst), .cfg_dvmode(cfg_dvmode), .stat_pin(stat_pin),
  .mod_rst_req(mod_rst_req), .rst_busy(rst_busy), .run_cnt(run_cnt)
);

// File: tb/sim_ovr_guard.sv
`timescale 1ns/1ps
module sim_ovr_guard;
  localparam int DW = 12, LAT = 7, RUN = 16, RLEN = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ovr_raw = 0, lf_sat = 0, mem_busy = 0;
  logic cfg_autorst = 0, cfg_dvmode = 0, cfg_dclk_inv = 0;
  logic [DW-1:0] din = '0;
  logic stat_pin, mod_rst_req, rst_busy, dclk_out;
  logic [DW-1:0] dout;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  ovr_guard #(.DW(DW), .LAT(LAT), .RUN_LEN(RUN), .RST_LEN(RLEN)) u0 (
    .clk(clk), .rst(rst), .ovr_raw(ovr_raw), .lf_sat(lf_sat),
    .mem_busy(mem_busy), .cfg_autorst(cfg_autorst), .cfg_dvmode(cfg_dvmode),
    .cfg_dclk_inv(cfg_dclk_inv), .din(din), .stat_pin(stat_pin),
    .mod_rst_req(mod_rst_req), .rst_busy(rst_busy), .dout(dout),
    .dclk_out(dclk_out)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic settle(input int n);
    ovr_raw = 0; lf_sat = 0;
    for (int i = 0; i < n; i++) tick();
  endtask

  function automatic logic [DW-1:0] pat(input int j);
    return DW'(j * 37 + 5);
  endfunction

  // continuous overrange from idle: reset starts at step 16, repeats every RUN+RLEN
  task automatic run_case(input int k);
    for (int i = 1; i <= k; i++) begin
      ovr_raw = 1;
      tick();
      chk("R6 request", mod_rst_req, (i >= RUN) && ((i - RUN) % (RUN + RLEN) == 0));
      chk("R10 busy window", rst_busy, (i >= RUN) && ((i - RUN) % (RUN + RLEN) < RLEN));
      chk("R4 pin", stat_pin, 1);
    end
    settle(RLEN + 2);
  endtask

  initial begin
    tick(); tick();
    chk("R1 stat", stat_pin, 0);
    chk("R1 req", mod_rst_req, 0);
    chk("R1 busy", rst_busy, 0);
    chk("R1 dout", dout, 0);
    rst = 0;

    // R11 latency
    for (int j = 0; j < 30; j++) begin
      din = pat(j);
      tick();
      chk("R11 dout", dout, (j >= LAT - 1) ? pat(j - (LAT - 1)) : '0);
    end

    // R12 data clock polarity
    for (int m = 0; m < 2; m++) begin
      cfg_dclk_inv = m[0];
      tick();
      chk("R12 high phase", dclk_out, m[0]);
      #2;
      chk("R12 low phase", dclk_out, !m[0]);
      tick();
    end
    cfg_dclk_inv = 0;

    // R2..R5 pin table sweep, no reset in progress
    for (int idx = 0; idx < 16; idx++) begin
      cfg_dvmode = idx[3]; cfg_autorst = idx[2]; ovr_raw = idx[1]; mem_busy = idx[0];
      tick();
      if (!idx[3] && !idx[2]) chk("R2 pin", stat_pin, idx[1]);
      if ( idx[3] && !idx[2]) chk("R3 pin", stat_pin, !idx[0]);
      if (!idx[3] &&  idx[2]) chk("R4 pin", stat_pin, idx[1]);
      if ( idx[3] &&  idx[2]) chk("R5 pin", stat_pin, !idx[0]);
      chk("R6 no early req", mod_rst_req, 0);
    end
    mem_busy = 0;
    settle(2);

    // R6 / R10 runs of every length, including re-trigger on a held overload
    cfg_dvmode = 0; cfg_autorst = 1;
    for (int k = 1; k <= 18; k++) run_case(k);
    run_case(2 * (RUN + RLEN) + 3);

    // R7 broken run
    for (int i = 0; i < 10; i++) begin ovr_raw = 1; tick(); end
    ovr_raw = 0; tick();
    for (int i = 1; i < RUN; i++) begin
      ovr_raw = 1; tick();
      chk("R7 no req after break", mod_rst_req, 0);
    end
    ovr_raw = 1; tick();
    chk("R7 req on 16th after break", mod_rst_req, 1);
    settle(RLEN + 2);

    // R8 saturation, normal mode, with saturation again inside the window (R10)
    lf_sat = 1; tick(); lf_sat = 0;
    chk("R8 sat req", mod_rst_req, 1);
    chk("R8 sat busy", rst_busy, 1);
    chk("R4 pin during reset", stat_pin, 1);
    for (int c = 1; c < RLEN; c++) begin
      lf_sat = (c == 3);
      tick();
      chk("R10 no retrigger", mod_rst_req, 0);
      chk("R10 busy held", rst_busy, 1);
      chk("R4 pin held", stat_pin, 1);
    end
    lf_sat = 0; tick();
    chk("R10 busy ends", rst_busy, 0);
    chk("R4 pin released", stat_pin, 0);
    settle(2);

    // R8 / R5 saturation in valid mode
    cfg_dvmode = 1;
    lf_sat = 1; tick(); lf_sat = 0;
    chk("R8 sat req dv", mod_rst_req, 1);
    for (int c = 1; c < RLEN; c++) begin
      tick();
      chk("R5 pin held low", stat_pin, 0);
    end
    tick();
    chk("R5 pin released", stat_pin, 1);
    cfg_dvmode = 0;
    settle(2);

    // R9 disabled: long run and saturation ignored, count held at zero
    cfg_autorst = 0;
    for (int i = 0; i < 40; i++) begin
      ovr_raw = 1; lf_sat = (i % 7 == 0);
      tick();
      chk("R9 no req", mod_rst_req, 0);
      chk("R9 no busy", rst_busy, 0);
      chk("R2 pin", stat_pin, 1);
    end
    lf_sat = 0; cfg_autorst = 1;
    for (int i = 1; i <= RUN; i++) begin
      tick();
      chk("R9 count from enable", mod_rst_req, i == RUN);
    end
    settle(RLEN + 2);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule